// File: doc/BRIEF.md
# Crosspoint Switch Serial Command Transmitter

This block sends single connect or disconnect commands to a bank of analog crosspoint switch chips. All chips listen on one shared serial data line and one shared serial clock, and each chip has a private strobe line. A command names a target chip, a 3-bit row (Y) address, a 4-bit column (X) address and a flag that selects connect or disconnect.

The block packs the fields into an 8-bit word and shifts it out most significant bit first, generating the serial clock itself. There is no frame select. Once the last bit has been clocked, the block raises the strobe of the addressed chip alone. The data line keeps the final bit during the strobe, and that bit tells the chip whether to close or open the addressed switch.

A valid/ready handshake accepts one command at a time. The block drops ready from acceptance until the strobe has ended and a short idle gap has passed. A command that names a chip outside the bank is refused: a one-cycle error pulse is raised and no strobe fires.

Top module: `xpt_cmd_tx`

## Requirements
- R1: The serial word is {Y[2:0], X[3:0], flag}: Y in bits 7:5, X in bits 4:1 and the connect flag in bit 0.
- R2: The word leaves on `ser_data` most significant bit first, with bit 7 sent in the first bit slot after acceptance. Each bit holds steady for its whole slot.
- R3: Each bit slot lasts 2*HALF_CYC cycles (default 3+3). `ser_clk` is low for the first HALF_CYC cycles and high for the rest. The first slot starts in the cycle after acceptance.
- R4: Right after the last bit slot, exactly one strobe is high: the bit whose index equals the accepted chip index. It stays high for STROBE_CYC cycles (default 50, which is 1 us at 50 MHz). All strobes are low at every other time.
- R5: While a strobe is high, `ser_data` carries the flag bit, where 1 means connect and 0 means disconnect, and `ser_clk` is low.
- R6: After the strobe, `ser_clk` stays low for GAP_CYC idle cycles (default 2) before ready returns. Outside bit slots the clock is always low.
- R7: `cmd_ready` is low from the cycle after acceptance until the gap ends. A command offered while the block is busy is ignored and causes no strobe.
- R8: A command with a chip index of N_CHIPS (12) or higher raises `err_pulse` for exactly one cycle, the cycle after acceptance. It produces no strobe and no clock edge, and ready returns after GAP_CYC cycles.
- R9: After reset, `cmd_ready` is 1 and `ser_clk`, `ser_data`, `strobe` and `err_pulse` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block can accept a command |
| cmd_chip | input | 4 | Target chip index |
| cmd_y | input | 3 | Row address |
| cmd_x | input | 4 | Column address |
| cmd_connect | input | 1 | 1 connects the switch, 0 disconnects it |
| ser_data | output | 1 | Shared serial data line |
| ser_clk | output | 1 | Shared serial clock, idles low |
| strobe | output | 12 | One strobe per chip, active high |
| err_pulse | output | 1 | One-cycle pulse when a chip index is refused |

## Verification
Commands are drawn from a table that covers all-zero and all-one address fields, alternating bit patterns, both flag values, and the first, middle and last chip indices. Rebuilding the word from the sampled serial stream separates field placement errors from bit-order errors. The strobe index shows whether chip decoding is correct, and the data level during the strobe shows whether the last bit is held. Directed cases cover a command offered while the block is busy, which must not produce a second strobe, and the out-of-range indices 12 and 15, which must give only the error pulse.

// File: rtl/xpt_cmd_tx.sv
module xpt_cmd_tx #(
  parameter int N_CHIPS    = 12,
  parameter int CLK_HZ     = 50_000_000,
  parameter int STROBE_CYC = CLK_HZ / 1_000_000,
  parameter int HALF_CYC   = 3,
  parameter int GAP_CYC    = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cmd_valid,
  output logic                        cmd_ready,
  input  logic [$clog2(N_CHIPS)-1:0]  cmd_chip,
  input  logic [2:0]                  cmd_y,
  input  logic [3:0]                  cmd_x,
  input  logic                        cmd_connect,
  output logic                        ser_data,
  output logic                        ser_clk,
  output logic [N_CHIPS-1:0]          strobe,
  output logic                        err_pulse
);
  localparam int CW     = $clog2(N_CHIPS);
  localparam int SLOT   = 2 * HALF_CYC;
  localparam int CMAX   = (STROBE_CYC > SLOT) ? ((STROBE_CYC > GAP_CYC) ? STROBE_CYC : GAP_CYC)
                                              : ((SLOT > GAP_CYC) ? SLOT : GAP_CYC);
  localparam int CNT_W  = $clog2(CMAX + 1);

  typedef enum logic [1:0] {IDLE, SHIFT, STB, GAP} state_t;

  state_t           state;
  logic [7:0]       word;
  logic [CW-1:0]    chip;
  logic [2:0]       bit_idx;
  logic [CNT_W-1:0] cnt;
  logic             err;

  wire accept  = cmd_valid && (state == IDLE);
  wire chip_ok = ({1'b0, cmd_chip} < (CW+1)'(N_CHIPS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= IDLE;
      word    <= '0;
      chip    <= '0;
      bit_idx <= '0;
      cnt     <= '0;
      err     <= 1'b0;
    end else begin
      err <= 1'b0;
      case (state)
        IDLE: if (accept) begin
          cnt <= '0;
          if (chip_ok) begin
            word    <= {cmd_y, cmd_x, cmd_connect};
            chip    <= cmd_chip;
            bit_idx <= 3'd7;
            state   <= SHIFT;
          end else begin
            err   <= 1'b1;
            state <= GAP;
          end
        end
        SHIFT: if (cnt == CNT_W'(SLOT - 1)) begin
          cnt <= '0;
          if (bit_idx == 3'd0) state <= STB;
          else bit_idx <= bit_idx - 3'd1;
        end else cnt <= cnt + 1'b1;
        STB: if (cnt == CNT_W'(STROBE_CYC - 1)) begin
          cnt   <= '0;
          state <= GAP;
        end else cnt <= cnt + 1'b1;
        GAP: if (cnt == CNT_W'(GAP_CYC - 1)) begin
          cnt   <= '0;
          state <= IDLE;
        end else cnt <= cnt + 1'b1;
        default: state <= IDLE;
      endcase
    end
  end

  assign cmd_ready = (state == IDLE);
  assign ser_data  = word[bit_idx];
  assign ser_clk   = (state == SHIFT) && (cnt >= CNT_W'(HALF_CYC));
  assign err_pulse = err;

  for (genvar i = 0; i < N_CHIPS; i++) begin : g_stb
    assign strobe[i] = (state == STB) && (chip == CW'(i));
  end
endmodule

// File: rtl/xpt_cmd_tx_chk.sv
module xpt_cmd_tx_chk #(
  parameter int N_CHIPS = 12
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       cmd_valid,
  input logic                       cmd_ready,
  input logic [$clog2(N_CHIPS)-1:0] cmd_chip,
  input logic                       ser_data,
  input logic                       ser_clk,
  input logic [N_CHIPS-1:0]         strobe,
  input logic                       err_pulse
);
  p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strobe));

  p_strobe_after_clk_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|strobe) |-> $past(ser_clk));

  p_strobe_clk_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|strobe) |-> !ser_clk);

  p_strobe_data_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((|strobe) && $past(|strobe)) |-> $stable(ser_data));

  p_idle_clk_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !ser_clk);

  p_busy_after_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  p_busy_during_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|strobe) |-> !cmd_ready);

  p_err_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> ($past(cmd_valid && cmd_ready) && ({1'b0, $past(cmd_chip)} >= ($clog2(N_CHIPS)+1)'(N_CHIPS))));

  p_err_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |=> !err_pulse);

  p_err_no_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> (strobe == '0));
endmodule

bind xpt_cmd_tx xpt_cmd_tx_chk #(.N_CHIPS(N_CHIPS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_chip(cmd_chip), .ser_data(ser_data), .ser_clk(ser_clk),
  .strobe(strobe), .err_pulse(err_pulse)
);

// File: tb/sim_xpt_cmd_tx.sv
module sim_xpt_cmd_tx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [3:0]  cmd_chip = '0;
  logic [2:0]  cmd_y = '0;
  logic [3:0]  cmd_x = '0;
  logic        cmd_connect = 1'b0;
  logic        ser_data, ser_clk, err_pulse;
  logic [11:0] strobe;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  xpt_cmd_tx u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_chip(cmd_chip), .cmd_y(cmd_y), .cmd_x(cmd_x), .cmd_connect(cmd_connect),
    .ser_data(ser_data), .ser_clk(ser_clk), .strobe(strobe), .err_pulse(err_pulse)
  );

  // {chip[3:0], y[2:0], x[3:0], connect}
  localparam logic [11:0] VEC [8] = '{
    {4'd0,  3'b000, 4'b0000, 1'b1},
    {4'd11, 3'b111, 4'b1111, 1'b0},
    {4'd5,  3'b101, 4'b0101, 1'b0},
    {4'd6,  3'b010, 4'b1010, 1'b1},
    {4'd1,  3'b100, 4'b0001, 1'b1},
    {4'd10, 3'b001, 4'b1000, 1'b0},
    {4'd3,  3'b110, 4'b0110, 1'b1},
    {4'd8,  3'b011, 4'b1001, 1'b0}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_cmd(input logic [3:0] ch, input logic [2:0] y, input logic [3:0] x,
                         input logic c, input bit busy_poke);
    logic [7:0] got;
    logic       prev;
    int clk_bad, stb_bad, hold_bad, slot_bad, rdy_bad, gap_bad;
    clk_bad = 0; stb_bad = 0; hold_bad = 0; slot_bad = 0; rdy_bad = 0; gap_bad = 0;
    got = '0; prev = 1'b0;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_chip = ch; cmd_y = y; cmd_x = x; cmd_connect = c; cmd_valid = 1'b1;
    @(negedge clk);
    if (busy_poke) begin
      cmd_chip = (ch == 4'd11) ? 4'd0 : ch + 4'd1;
      cmd_connect = ~c;
    end else cmd_valid = 1'b0;
    for (int i = 1; i <= 100; i++) begin
      if (i == 90) cmd_valid = 1'b0;
      if (cmd_ready || err_pulse) rdy_bad++;
      if (i <= 48) begin
        int j, ph;
        j = (i - 1) / 6; ph = (i - 1) % 6;
        if (ser_clk !== (ph >= 3)) clk_bad++;
        if (ph == 3) got[7 - j] = ser_data;
        if (ph > 0 && ser_data !== prev) slot_bad++;
        if (strobe !== 12'd0) stb_bad++;
      end else if (i <= 98) begin
        if (strobe !== (12'd1 << ch)) stb_bad++;
        if (ser_data !== c || ser_clk !== 1'b0) hold_bad++;
      end else begin
        if (strobe !== 12'd0) stb_bad++;
        if (ser_clk !== 1'b0) gap_bad++;
      end
      prev = ser_data;
      @(negedge clk);
    end
    check(got == {y, x, c}, "R1 R2 word", got, {y, x, c});
    check(slot_bad == 0, "R2 bit steady in slot", slot_bad, 0);
    check(clk_bad == 0, "R3 clock shape", clk_bad, 0);
    check(stb_bad == 0, "R4 strobe select/width", stb_bad, 0);
    check(hold_bad == 0, "R5 flag held during strobe", hold_bad, 0);
    check(gap_bad == 0, "R6 clock low in gap", gap_bad, 0);
    check(rdy_bad == 0 && cmd_ready === 1'b1, "R7 ready timing", rdy_bad, 0);
  endtask

  task automatic run_bad(input logic [3:0] ch);
    int bad;
    bad = 0;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_chip = ch; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (err_pulse !== 1'b1) bad++;
    for (int i = 1; i <= 2; i++) begin
      if (i == 2 && err_pulse !== 1'b0) bad++;
      if (cmd_ready !== 1'b0 || strobe !== 12'd0 || ser_clk !== 1'b0) bad++;
      @(negedge clk);
    end
    if (cmd_ready !== 1'b1) bad++;
    for (int i = 0; i < 60; i++) begin
      if (strobe !== 12'd0 || ser_clk !== 1'b0 || err_pulse !== 1'b0) bad++;
      @(negedge clk);
    end
    check(bad == 0, "R8 refused chip index", bad, 0);
  endtask

  initial begin
    #4_000_000;
    n_bad++; n_chk++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check(cmd_ready === 1'b1 && ser_clk === 1'b0 && ser_data === 1'b0
          && strobe === 12'd0 && err_pulse === 1'b0, "R9 reset state",
          {cmd_ready, ser_clk, ser_data, err_pulse}, 4'b1000);
    for (int k = 0; k < 8; k++)
      run_cmd(VEC[k][11:8], VEC[k][7:5], VEC[k][4:1], VEC[k][0], 1'b0);
    // R7 command held while busy must not strobe another chip
    run_cmd(4'd4, 3'b011, 4'b1100, 1'b1, 1'b1);
    run_bad(4'd12);
    run_bad(4'd15);
    run_cmd(4'd7, 3'b101, 4'b0011, 1'b1, 1'b0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule